// File: doc/BRIEF.md
# USB Device Event Status and Interrupt Register Block

This block sits between the USB protocol engine and a host CPU. It turns three one-cycle event pulses into sticky status flags: bus reset seen, start-of-frame received, and start-of-frame expected but missing. Software reads and clears these flags over a small synchronous register port. Each flag has its own enable bit, and the enabled pending flags are combined into one registered interrupt line.

The block also holds the device state that a bus reset affects. A bus reset event clears the function address and the per-endpoint registers. The configuration and enable registers keep their values. While a bus-reset flag is pending, the receive and transmit enables are held low, so no traffic runs until software has dealt with the reset. On each start-of-frame event the block captures the frame number from the protocol engine and pulses a strobe.

Top module: `usb_evt_status`

## Requirements
- R1: After the asynchronous reset, every flag, enable, configuration, address, endpoint and frame register reads 0, and irq_o, rx_en_o, tx_en_o and frame_cap_o are low.
- R2: An event pulse sets its flag in the status register at byte address 0x00. Bus reset uses bit 10, start-of-frame uses bit 9 and missed start-of-frame uses bit 8. The flag is visible from the clock edge that samples the pulse.
- R3: A write to 0x00 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. No other path clears a flag except the asynchronous reset.
- R4: When an event pulse and a write of 0 reach the same flag in the same cycle, the flag ends up set.
- R5: The enable register at 0x04 uses the same bit positions (10, 9, 8). irq_o is the registered OR of all flags ANDed with their enable bits, so it follows the flag and enable state one cycle later.
- R6: The configuration register at 0x08 holds the receive enable in bit 0 and the transmit enable in bit 1. rx_en_o and tx_en_o follow these bits but are forced low while the bus-reset flag is set.
- R7: A bus-reset event clears the function address (0x10, 7 bits) and every endpoint register (0x20 + 4*n, 16 bits), and it wins over a write in the same cycle. The enable and configuration registers are not changed by it.
- R8: A start-of-frame event loads frame_num_i into the read-only frame register at 0x0C (11 bits) and raises frame_cap_o for exactly the following cycle.
- R9: Status bits other than 10:8 read as 0. The enable register reads 0 outside bits 10:8. Unmapped addresses read 0, and writes to them change nothing.
- R10: reg_rdata_o is registered. In the cycle after reg_re_i it holds the value the addressed register had before that clock edge, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_rst_evt_i | input | 1 | One-cycle pulse: bus reset detected |
| sof_evt_i | input | 1 | One-cycle pulse: start-of-frame packet received |
| esof_evt_i | input | 1 | One-cycle pulse: start-of-frame expected but missing |
| frame_num_i | input | FNW (11) | Frame number from the protocol engine |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Byte address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt request |
| rx_en_o | output | 1 | Receive enable after the reset block |
| tx_en_o | output | 1 | Transmit enable after the reset block |
| frame_cap_o | output | 1 | Strobe: frame number captured |
| dev_addr_o | output | DAW (7) | Device function address |
| ep_cfg_o | output | NUM_EP*16 | Endpoint registers, endpoint n in bits n*16 +: 16 |

## Verification
Two functions can meet in the same cycle. A hardware event can land on a flag while software writes 0 to that flag, and a bus reset can land while software writes the function address or an endpoint register. The bench provokes both on purpose: directed steps pulse the event in the very cycle of the write, and the random phase mixes events with writes at a high rate. A bench-side model of the registers, built from R4 and R7, judges each outcome. The model is compared against the read-back values and against the address and enable pins in every cycle.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NFLAG = 3;       // 0: missed sof, 1: sof, 2: bus reset
  localparam int FLAG_LSB = 8;
  localparam int IDX_ESOF = 0;
  localparam int IDX_SOF = 1;
  localparam int IDX_RST = 2;
  localparam int CFG_W = 2;

  localparam logic [AW-1:0] A_STAT  = 8'h00;
  localparam logic [AW-1:0] A_MASK  = 8'h04;
  localparam logic [AW-1:0] A_CFG   = 8'h08;
  localparam logic [AW-1:0] A_FRAME = 8'h0C;
  localparam logic [AW-1:0] A_DADDR = 8'h10;
  localparam logic [AW-1:0] A_EP0   = 8'h20;

  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/usb_evt_flag.sv
module usb_evt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/usb_evt_irq.sv
module usb_evt_irq #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(flag_i & en_i);
  end
endmodule

// File: rtl/usb_evt_ep_bank.sv
module usb_evt_ep_bank #(
  parameter int NUM_EP = 4,
  parameter int DAW    = 7,
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter logic [AW-1:0] DADDR_A = 8'h10,
  parameter logic [AW-1:0] EP_BASE = 8'h20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_rst_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DAW-1:0]       dev_addr_o,
  output logic [NUM_EP*DW-1:0] ep_o,
  output logic [DW-1:0]        rd_data_o
);
  logic [DW-1:0]     ep_q [NUM_EP];
  logic [NUM_EP-1:0] ep_hit;
  logic              daddr_hit;

  assign daddr_hit = (addr_i == DADDR_A);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    dev_addr_o <= '0;
    else if (bus_rst_i)             dev_addr_o <= '0;
    else if (wr_en_i && daddr_hit)  dev_addr_o <= wdata_i[DAW-1:0];
  end

  for (genvar n = 0; n < NUM_EP; n++) begin : g_ep
    localparam logic [AW-1:0] EP_A = EP_BASE + AW'(4 * n);
    assign ep_hit[n] = (addr_i == EP_A);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    ep_q[n] <= '0;
      else if (bus_rst_i)             ep_q[n] <= '0;
      else if (wr_en_i && ep_hit[n])  ep_q[n] <= wdata_i;
    end
    assign ep_o[n*DW +: DW] = ep_q[n];
  end

  always_comb begin
    rd_data_o = '0;
    if (daddr_hit) rd_data_o = DW'(dev_addr_o);
    for (int n = 0; n < NUM_EP; n++) begin
      if (ep_hit[n]) rd_data_o = ep_q[n];
    end
  end
endmodule

// File: rtl/usb_evt_status.sv
module usb_evt_status
  import usb_evt_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int FNW    = 11,
  parameter int DAW    = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_rst_evt_i,
  input  logic                 sof_evt_i,
  input  logic                 esof_evt_i,
  input  logic [FNW-1:0]       frame_num_i,
  input  logic                 reg_we_i,
  input  logic                 reg_re_i,
  input  logic [AW-1:0]        reg_addr_i,
  input  logic [DW-1:0]        reg_wdata_i,
  output logic [DW-1:0]        reg_rdata_o,
  output logic                 irq_o,
  output logic                 rx_en_o,
  output logic                 tx_en_o,
  output logic                 frame_cap_o,
  output logic [DAW-1:0]       dev_addr_o,
  output logic [NUM_EP*DW-1:0] ep_cfg_o
);
  flag_vec_t        evt_vec, clr_vec, flag_q, mask_q;
  logic [CFG_W-1:0] cfg_q;
  logic [FNW-1:0]   frame_q;
  logic [DW-1:0]    bank_rd, rd_mux;
  logic             stat_wr;

  assign evt_vec = {bus_rst_evt_i, sof_evt_i, esof_evt_i};
  assign stat_wr = reg_we_i && (reg_addr_i == A_STAT);

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign clr_vec[i] = stat_wr && !reg_wdata_i[FLAG_LSB+i];
    usb_evt_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (evt_vec[i]),
      .clr_i (clr_vec[i]),
      .q_o   (flag_q[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      cfg_q  <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == A_MASK) mask_q <= reg_wdata_i[FLAG_LSB +: NFLAG];
      if (reg_addr_i == A_CFG)  cfg_q  <= reg_wdata_i[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q     <= '0;
      frame_cap_o <= 1'b0;
    end else begin
      frame_cap_o <= sof_evt_i;
      if (sof_evt_i) frame_q <= frame_num_i;
    end
  end

  usb_evt_irq #(.N(NFLAG)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .flag_i(flag_q),
    .en_i  (mask_q),
    .irq_o (irq_o)
  );

  usb_evt_ep_bank #(
    .NUM_EP (NUM_EP),
    .DAW    (DAW),
    .AW     (AW),
    .DW     (DW),
    .DADDR_A(A_DADDR),
    .EP_BASE(A_EP0)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_rst_i (bus_rst_evt_i),
    .wr_en_i   (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .dev_addr_o(dev_addr_o),
    .ep_o      (ep_cfg_o),
    .rd_data_o (bank_rd)
  );

  // pending bus reset blocks traffic
  assign rx_en_o = cfg_q[0] && !flag_q[IDX_RST];
  assign tx_en_o = cfg_q[1] && !flag_q[IDX_RST];

  always_comb begin
    rd_mux = '0;
    case (reg_addr_i)
      A_STAT:  rd_mux[FLAG_LSB +: NFLAG] = flag_q;
      A_MASK:  rd_mux[FLAG_LSB +: NFLAG] = mask_q;
      A_CFG:   rd_mux = DW'(cfg_q);
      A_FRAME: rd_mux = DW'(frame_q);
      default: rd_mux = bank_rd;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reg_rdata_o <= '0;
    else if (reg_re_i) reg_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/usb_evt_status_chk.sv
module usb_evt_status_chk #(
  parameter int N   = 3,
  parameter int FNW = 11,
  parameter int DAW = 7
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [N-1:0]   evt_i,
  input logic [N-1:0]   clr_i,
  input logic [N-1:0]   flag_i,
  input logic [N-1:0]   mask_i,
  input logic           irq_i,
  input logic           rx_en_i,
  input logic           tx_en_i,
  input logic           sof_i,
  input logic [FNW-1:0] frame_num_i,
  input logic [FNW-1:0] frame_q_i,
  input logic           frame_cap_i,
  input logic [DAW-1:0] dev_addr_i
);
  a_r2_r4_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_i & $past(evt_i)) == $past(evt_i)));

  a_r3_fall_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~flag_i & $past(flag_i) & ~$past(clr_i)) == '0));

  a_r5_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_i == |($past(flag_i) & $past(mask_i))));

  a_r6_reset_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i[N-1] |-> (!rx_en_i && !tx_en_i));

  a_r7_addr_wiped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[N-1] |=> (dev_addr_i == '0));

  a_r8_frame_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> (frame_cap_i && frame_q_i == $past(frame_num_i)));

  a_r8_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_i |=> !frame_cap_i);
endmodule

bind usb_evt_status usb_evt_status_chk #(.N(3), .FNW(FNW), .DAW(DAW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_vec),
  .clr_i      (clr_vec),
  .flag_i     (flag_q),
  .mask_i     (mask_q),
  .irq_i      (irq_o),
  .rx_en_i    (rx_en_o),
  .tx_en_i    (tx_en_o),
  .sof_i      (sof_evt_i),
  .frame_num_i(frame_num_i),
  .frame_q_i  (frame_q),
  .frame_cap_i(frame_cap_o),
  .dev_addr_i (dev_addr_o)
);

// File: tb/usb_evt_status_tb.sv
module usb_evt_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EP = 4;
  localparam int FNW = 11;
  localparam int DAW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst_evt, sof_evt, esof_evt;
  logic [FNW-1:0] frame_num;
  logic reg_we, reg_re;
  logic [7:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic irq, rx_en, tx_en, frame_cap;
  logic [DAW-1:0] dev_addr;
  logic [NUM_EP*16-1:0] ep_cfg;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_evt_status #(.NUM_EP(NUM_EP), .FNW(FNW), .DAW(DAW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_rst_evt_i(bus_rst_evt), .sof_evt_i(sof_evt), .esof_evt_i(esof_evt),
    .frame_num_i(frame_num),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .rx_en_o(rx_en), .tx_en_o(tx_en), .frame_cap_o(frame_cap),
    .dev_addr_o(dev_addr), .ep_cfg_o(ep_cfg)
  );

  // model state
  logic [2:0]     m_flag = '0, m_mask = '0;
  logic [1:0]     m_cfg = '0;
  logic [FNW-1:0] m_frame = '0;
  logic [DAW-1:0] m_addr = '0;
  logic [15:0]    m_ep [NUM_EP];
  logic [15:0]    m_rdata = '0;
  logic           m_irq = 1'b0, m_cap = 1'b0;

  function automatic logic [15:0] model_read(input logic [7:0] a);
    logic [15:0] v = '0;
    case (a)
      8'h00: v[10:8] = m_flag;
      8'h04: v[10:8] = m_mask;
      8'h08: v = {14'b0, m_cfg};
      8'h0C: v = {5'b0, m_frame};
      8'h10: v = {9'b0, m_addr};
      default: begin
        for (int n = 0; n < NUM_EP; n++)
          if (a == 8'h20 + 8'(4*n)) v = m_ep[n];
      end
    endcase
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_pins();
    check("R5 irq", 32'(irq), 32'(m_irq));
    check("R6 rx_en", 32'(rx_en), 32'(m_cfg[0] & ~m_flag[2]));
    check("R6 tx_en", 32'(tx_en), 32'(m_cfg[1] & ~m_flag[2]));
    check("R7 dev_addr", 32'(dev_addr), 32'(m_addr));
    check("R8 frame_cap", 32'(frame_cap), 32'(m_cap));
  endtask

  // one cycle; called at negedge, returns at next negedge
  task automatic step(input logic we, input logic [7:0] a, input logic [15:0] wd,
                      input logic re, input logic [2:0] ev, input logic [FNW-1:0] fn,
                      input string rtag);
    logic [15:0] rd_next;
    reg_we = we; reg_addr = a; reg_wdata = wd; reg_re = re;
    {bus_rst_evt, sof_evt, esof_evt} = ev; frame_num = fn;
    rd_next = re ? model_read(a) : m_rdata;
    @(posedge clk);
    m_irq = |(m_flag & m_mask);
    for (int i = 0; i < 3; i++)
      if (ev[i]) m_flag[i] = 1'b1;
      else if (we && a == 8'h00 && !wd[8+i]) m_flag[i] = 1'b0;
    if (we && a == 8'h04) m_mask = wd[10:8];
    if (we && a == 8'h08) m_cfg = wd[1:0];
    if (ev[1]) m_frame = fn;
    m_cap = ev[1];
    if (ev[2]) m_addr = '0;
    else if (we && a == 8'h10) m_addr = wd[DAW-1:0];
    for (int n = 0; n < NUM_EP; n++)
      if (ev[2]) m_ep[n] = '0;
      else if (we && a == 8'h20 + 8'(4*n)) m_ep[n] = wd;
    m_rdata = rd_next;
    @(negedge clk);
    reg_we = 1'b0; reg_re = 1'b0; {bus_rst_evt, sof_evt, esof_evt} = '0;
    check_pins();
    if (re) check(rtag, 32'(reg_rdata), 32'(m_rdata));
    for (int n = 0; n < NUM_EP; n++)
      check("R7 ep_cfg", 32'(ep_cfg[n*16 +: 16]), 32'(m_ep[n]));
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    step(1'b0, a, '0, 1'b1, 3'b000, '0, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    step(1'b1, a, d, 1'b0, 3'b000, '0, "R10");
  endtask

  task automatic ev_only(input logic [2:0] ev, input logic [FNW-1:0] fn);
    step(1'b0, 8'h00, '0, 1'b0, ev, fn, "R2");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog R1 act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] addrs [12];
    for (int n = 0; n < NUM_EP; n++) m_ep[n] = '0;
    addrs = '{8'h00, 8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h24, 8'h2C,
              8'h14, 8'h30, 8'h02};
    reg_we = 0; reg_re = 0; reg_addr = 0; reg_wdata = 0;
    bus_rst_evt = 0; sof_evt = 0; esof_evt = 0; frame_num = 0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 rx_en", 32'(rx_en), 0);
    check("R1 frame_cap", 32'(frame_cap), 0);
    foreach (addrs[k]) rd(addrs[k], "R1 read");

    // R2 each event sets its own bit
    ev_only(3'b001, '0); rd(8'h00, "R2 esof bit8");
    ev_only(3'b010, 11'h123); rd(8'h00, "R2 sof bit9");
    ev_only(3'b100, '0); rd(8'h00, "R2 reset bit10");

    // R3 write 1 keeps, write 0 clears
    wr(8'h00, 16'hFFFF); rd(8'h00, "R3 write ones keep");
    wr(8'h00, 16'hFBFF); rd(8'h00, "R3 clear reset only");
    wr(8'h00, 16'h0000); rd(8'h00, "R3 clear all");

    // R4 same-cycle set and clear
    step(1'b1, 8'h00, 16'h0000, 1'b0, 3'b010, 11'h055, "R4");
    rd(8'h00, "R4 set wins");
    wr(8'h00, 16'h0000);

    // R5 irq via mask
    wr(8'h04, 16'h0100); ev_only(3'b001, '0); ev_only(3'b000, '0);
    rd(8'h04, "R5 mask read");
    wr(8'h00, 16'h0000); ev_only(3'b000, '0);

    // R6 config gated by pending reset
    wr(8'h08, 16'h0003); ev_only(3'b100, '0); ev_only(3'b000, '0);
    wr(8'h00, 16'h0000); ev_only(3'b000, '0);

    // R7 reset wipes address and endpoints, wins over write
    wr(8'h10, 16'h002A); wr(8'h24, 16'hBEEF); wr(8'h04, 16'h0700);
    step(1'b1, 8'h10, 16'h0055, 1'b0, 3'b100, '0, "R7");
    rd(8'h10, "R7 addr wiped"); rd(8'h24, "R7 ep wiped");
    rd(8'h04, "R7 mask kept"); rd(8'h08, "R7 cfg kept");
    wr(8'h00, 16'h0000);

    // R8 frame capture
    ev_only(3'b010, 11'h5A5); rd(8'h0C, "R8 frame");
    wr(8'h0C, 16'h0001); rd(8'h0C, "R8 frame read only");

    // R9 reserved bits and unmapped addresses
    wr(8'h04, 16'hF8FF); rd(8'h04, "R9 mask reserved");
    wr(8'h14, 16'hFFFF); rd(8'h14, "R9 unmapped");
    rd(8'h00, "R9 status reserved");

    // R10 read and write in same cycle returns the old value
    step(1'b1, 8'h24, 16'h1357, 1'b1, 3'b000, '0, "R10 old value");
    rd(8'h24, "R10 new value");

    // random mix
    for (int it = 0; it < 4000; it++) begin
      logic [7:0] a;
      logic [2:0] ev;
      a = addrs[$urandom_range(11)];
      ev[0] = ($urandom_range(7) == 0);
      ev[1] = ($urandom_range(7) == 0);
      ev[2] = ($urandom_range(15) == 0);
      step($urandom_range(2) == 0, a, 16'($urandom), $urandom_range(1) == 0,
           ev, FNW'($urandom), "R10 random read");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule